// File: doc/BRIEF.md
# Packing Vector Configuration Generator

This block turns a short description of how protocol words sit inside a FIFO entry into the control words that a byte-lane unpacking datapath uses. The description has three parts: the number of bits in a protocol word, the number of words held in one FIFO entry, and whether bits are sent most-significant first. A single-cycle `start` strobe captures the three inputs. The block then builds up to four byte-sized slot descriptors, one per clock. A protocol word wider than eight bits is spread over several consecutive slots. Each slot records where its bit run starts, which way the run goes, how many bits it holds, and whether it is the final slot.

When the walk ends, the slots are packed into two 32-bit configuration words. A two-bit granularity code is published at the same time, and `done` pulses for one cycle. A combination that would need no slots, or more than four, produces no configuration. In that case `done` pulses with `error` set and the previously published outputs stay as they were. A start strobe that arrives while a calculation is running has no effect.

Top module: `pack_vec_gen`

## Requirements
- R1: The slot count is ceil(word_bits/8) × words_per_entry. When that count is 0 or greater than 4, or word_bits exceeds 32, `done` pulses with `error`=1 and `cfg_lo`, `cfg_hi` and `gran` keep their previous values.
- R2: Slot 0 starts at bit word_bits−1 when `msb_first`=1 and at bit 0 otherwise. Within one protocol word, each further slot starts 8 bits lower (MSB first) or 8 bits higher (LSB first).
- R3: The length field of a slot is min(bits still left in the current word, 8) − 1. Its order bit equals the captured `msb_first`.
- R4: After slot k uses up the last 8 or fewer bits of a word, slot k+1 starts at (k+1)×8 plus the start position of slot 0, and the count of bits left reloads to word_bits.
- R5: Only the last computed slot has its stop bit set. Slots beyond the count are all zero.
- R6: Each slot is 10 bits wide: start position in bits [9:5], order in [4], length in [3:1], stop in [0]. Slot 0 goes in `cfg_lo[9:0]`, slot 1 in `cfg_lo[19:10]`, slot 2 in `cfg_hi[9:0]` and slot 3 in `cfg_hi[19:10]`. Bits [31:20] of both words are zero.
- R7: On a successful calculation, `gran` becomes word_bits/16 (0: four 8-bit words, 1: two 16-bit words, 2: one 32-bit word). It is updated only when words_per_entry is nonzero or word_bits is 32.
- R8: A start taken at clock edge E0 computes one slot per edge, at E1 to En, where n is the slot count. `done` is a one-cycle pulse after edge E(n+1), together with the new outputs, or after E1 for a rejected combination. `busy` is high from E0 until `done` rises.
- R9: `start` while `busy` is high is ignored. The running calculation keeps its captured inputs, and no second `done` follows.
- R10: After reset, `busy`, `done`, `error`, `cfg_lo`, `cfg_hi` and `gran` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled when idle |
| word_bits | input | 6 | Bits per protocol word |
| words_per_entry | input | 3 | Protocol words per FIFO entry |
| msb_first | input | 1 | 1: bits run from MSB to LSB |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request was rejected; valid from `done` until the next start |
| cfg_lo | output | 32 | Slots 0 and 1 |
| cfg_hi | output | 32 | Slots 2 and 3 |
| gran | output | 2 | Byte granularity code |

## Verification
The embedded properties check the following on every cycle: `done` is a single-cycle pulse that never overlaps `busy`; the walk advances one slot per clock; a rejected request goes straight to the finish state and leaves all published outputs unchanged; and every successful result carries exactly one stop bit. The values themselves cannot be shown by these properties. Only the bench scenarios show them: the start positions, the per-word stepping and reload, the length fields, the granularity code, the exact latency, and a mid-run start having no effect. The bench compares each result against its own model over directed corner widths and random combinations.

// File: rtl/pvg_pkg.sv
`timescale 1ns/1ps
package pvg_pkg;

    localparam int unsigned LANE_BITS = 8;
    localparam int unsigned SLOT_NUM  = 4;
    localparam int unsigned POS_W     = 5;
    localparam int unsigned LEN_W     = 3;
    localparam int unsigned SLOT_W    = POS_W + 1 + LEN_W + 1;
    localparam int unsigned CFG_W     = 32;

    // one slot descriptor: pos [9:5], order [4], len [3:1], stop [0]
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             order;
        logic [LEN_W-1:0] len;
        logic             stop;
    } slot_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WALK   = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

    function automatic int unsigned lanes_for(input int unsigned bits);
        return (bits + LANE_BITS - 1) / LANE_BITS;
    endfunction

    function automatic logic [1:0] gran_of(input int unsigned bits);
        return 2'(bits / 16);
    endfunction

endpackage

// File: rtl/pvg_setup.sv
`timescale 1ns/1ps
module pvg_setup
    import pvg_pkg::*;
#(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned BITS_W   = 6,
    parameter int unsigned WORDS_W  = 3,
    parameter int unsigned IDX_W    = 7,
    parameter int unsigned CNT_W    = 3
) (
    input  logic [BITS_W-1:0]  word_bits,
    input  logic [WORDS_W-1:0] words,
    input  logic               msb,
    output logic [CNT_W-1:0]   slot_total,
    output logic               reject,
    output logic [IDX_W-1:0]   pos0
);

    int unsigned total;

    always_comb begin
        total      = lanes_for(32'(word_bits)) * 32'(words);
        reject     = (total == 0) || (total > SLOT_NUM) || (32'(word_bits) > MAX_BITS);
        slot_total = reject ? '0 : CNT_W'(total);
        pos0       = msb ? (IDX_W'(word_bits) - 1'b1) : '0;
    end

endmodule

// File: rtl/pvg_step.sv
`timescale 1ns/1ps
module pvg_step
    import pvg_pkg::*;
#(
    parameter int unsigned BITS_W = 6,
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [IDX_W-1:0]  cur_pos,
    input  logic [BITS_W-1:0] left,
    input  logic [SEL_W-1:0]  sel,
    input  logic              msb,
    input  logic [BITS_W-1:0] word_bits,
    input  logic [IDX_W-1:0]  pos0,
    input  logic              last,
    output slot_t             slot,
    output logic [IDX_W-1:0]  nxt_pos,
    output logic [BITS_W-1:0] nxt_left
);

    logic              fits;
    logic [BITS_W-1:0] chunk;

    always_comb begin
        fits       = (left <= BITS_W'(LANE_BITS));
        chunk      = fits ? left : BITS_W'(LANE_BITS);
        slot.pos   = cur_pos[POS_W-1:0];
        slot.order = msb;
        slot.len   = LEN_W'(chunk - 1'b1);
        slot.stop  = last;
        if (fits) begin
            // word exhausted: jump to the base of the next word
            nxt_pos  = IDX_W'((32'(sel) + 1) * LANE_BITS) + pos0;
            nxt_left = word_bits;
        end else begin
            nxt_pos  = msb ? (cur_pos - IDX_W'(LANE_BITS)) : (cur_pos + IDX_W'(LANE_BITS));
            nxt_left = left - BITS_W'(LANE_BITS);
        end
    end

endmodule

// File: rtl/pvg_ctrl.sv
`timescale 1ns/1ps
module pvg_ctrl
    import pvg_pkg::*;
#(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             reject,
    input  logic [CNT_W-1:0] slot_total,
    output logic             busy,
    output logic             load,
    output logic             walk,
    output logic             last,
    output logic [SEL_W-1:0] sel,
    output logic             commit,
    output logic             done,
    output logic             err
);

    phase_e           ph;
    logic [CNT_W-1:0] total_q;
    logic [SEL_W-1:0] sel_q;
    logic             fail_q;
    logic             done_q;
    logic             err_q;

    assign busy   = (ph != PH_IDLE);
    assign load   = (ph == PH_IDLE) && start;
    assign walk   = (ph == PH_WALK);
    assign last   = walk && (CNT_W'(sel_q) == (total_q - 1'b1));
    assign sel    = sel_q;
    assign commit = (ph == PH_FINISH) && !fail_q;
    assign done   = done_q;
    assign err    = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            total_q <= '0;
            sel_q   <= '0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        total_q <= slot_total;
                        sel_q   <= '0;
                        fail_q  <= reject;
                        err_q   <= 1'b0;
                        ph      <= reject ? PH_FINISH : PH_WALK;
                    end
                end
                PH_WALK: begin
                    if (last) ph <= PH_FINISH;
                    else      sel_q <= sel_q + 1'b1;
                end
                PH_FINISH: begin
                    done_q <= 1'b1;
                    err_q  <= fail_q;
                    ph     <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_busy_not_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    a_r9_walk_advances: assert property (@(posedge clk) disable iff (rst)
        (walk && !last) |=> (walk && (sel == $past(sel) + 1'b1)));

    a_r1_reject_skips_walk: assert property (@(posedge clk) disable iff (rst)
        (load && reject) |=> (busy && !walk));

endmodule

// File: rtl/pack_vec_gen.sv
`timescale 1ns/1ps
module pack_vec_gen
    import pvg_pkg::*;
#(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned WORDS_W  = 3,
    localparam int unsigned BITS_W  = $clog2(MAX_BITS + 1),
    localparam int unsigned IDX_W   = BITS_W + 1,
    localparam int unsigned CNT_W   = $clog2(SLOT_NUM + 1),
    localparam int unsigned SEL_W   = $clog2(SLOT_NUM),
    localparam int unsigned HALF    = SLOT_NUM / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BITS_W-1:0]  word_bits,
    input  logic [WORDS_W-1:0] words_per_entry,
    input  logic               msb_first,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic [CFG_W-1:0]   cfg_lo,
    output logic [CFG_W-1:0]   cfg_hi,
    output logic [1:0]         gran
);

    logic [CNT_W-1:0]   slot_total;
    logic               reject;
    logic [IDX_W-1:0]   pos0;
    logic               load, walk, last, commit;
    logic [SEL_W-1:0]   sel;

    logic [BITS_W-1:0]  bits_q, left_q, nxt_left;
    logic [WORDS_W-1:0] words_q;
    logic               msb_q;
    logic [IDX_W-1:0]   pos0_q, pos_q, nxt_pos;
    slot_t              slot_now;
    slot_t              slot_q [SLOT_NUM];
    logic [SLOT_NUM*SLOT_W-1:0] flat;

    pvg_setup #(
        .MAX_BITS(MAX_BITS), .BITS_W(BITS_W), .WORDS_W(WORDS_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_setup (
        .word_bits (word_bits),
        .words     (words_per_entry),
        .msb       (msb_first),
        .slot_total(slot_total),
        .reject    (reject),
        .pos0      (pos0)
    );

    pvg_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .reject    (reject),
        .slot_total(slot_total),
        .busy      (busy),
        .load      (load),
        .walk      (walk),
        .last      (last),
        .sel       (sel),
        .commit    (commit),
        .done      (done),
        .err       (error)
    );

    pvg_step #(.BITS_W(BITS_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_step (
        .cur_pos  (pos_q),
        .left     (left_q),
        .sel      (sel),
        .msb      (msb_q),
        .word_bits(bits_q),
        .pos0     (pos0_q),
        .last     (last),
        .slot     (slot_now),
        .nxt_pos  (nxt_pos),
        .nxt_left (nxt_left)
    );

    // captured request and walk cursor
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q  <= '0;
            words_q <= '0;
            msb_q   <= 1'b0;
            pos0_q  <= '0;
            pos_q   <= '0;
            left_q  <= '0;
        end else if (load) begin
            bits_q  <= word_bits;
            words_q <= words_per_entry;
            msb_q   <= msb_first;
            pos0_q  <= pos0;
            pos_q   <= pos0;
            left_q  <= word_bits;
        end else if (walk) begin
            pos_q  <= nxt_pos;
            left_q <= nxt_left;
        end
    end

    // slot storage, cleared on every accepted start
    for (genvar k = 0; k < SLOT_NUM; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || load)
                slot_q[k] <= '0;
            else if (walk && (32'(sel) == k))
                slot_q[k] <= slot_now;
        end
        assign flat[k*SLOT_W +: SLOT_W] = slot_q[k];
    end

    // published outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_lo <= '0;
            cfg_hi <= '0;
            gran   <= '0;
        end else if (commit) begin
            cfg_lo <= CFG_W'(flat[HALF*SLOT_W-1:0]);
            cfg_hi <= CFG_W'(flat[SLOT_NUM*SLOT_W-1:HALF*SLOT_W]);
            if ((words_q != '0) || (32'(bits_q) == 32))
                gran <= gran_of(32'(bits_q));
        end
    end

    a_r1_reject_holds_cfg: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> ($stable(cfg_lo) && $stable(cfg_hi) && $stable(gran)));

    a_r5_one_stop: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> ($countones({cfg_lo[0], cfg_lo[SLOT_W], cfg_hi[0], cfg_hi[SLOT_W]}) == 1));

    a_r3_order_bit: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> (cfg_lo[4] == msb_q));

endmodule

// File: tb/test_pack_vec_gen.sv
`timescale 1ns/1ps
module test_pack_vec_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  bits_i = '0;
    logic [2:0]  words_i = '0;
    logic        msb_i = 1'b0;
    logic        busy, done, error;
    logic [31:0] cfg_lo, cfg_hi;
    logic [1:0]  gran;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_lo = '0;
    logic [31:0] exp_hi = '0;
    logic [1:0]  exp_gran = '0;

    always #10 clk = ~clk;

    pack_vec_gen i_pack_vec_gen (
        .clk(clk), .rst(rst), .start(start), .word_bits(bits_i),
        .words_per_entry(words_i), .msb_first(msb_i), .busy(busy),
        .done(done), .error(error), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .gran(gran)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lanes(input int b, input int w);
        return ((b + 7) / 8) * w;
    endfunction

    // expected slot k, walking the rules from slot 0
    function automatic logic [9:0] slot_model(input int b, input int w, input bit m, input int k);
        int n = lanes(b, w);
        int p0 = m ? b - 1 : 0;
        int p = p0;
        int r = b;
        int ln;
        if (k >= n) return '0;
        for (int j = 0; j < k; j++) begin
            if (r <= 8) begin
                p = (j + 1) * 8 + p0;
                r = b;
            end else begin
                p = m ? p - 8 : p + 8;
                r = r - 8;
            end
        end
        ln = ((r < 8) ? r : 8) - 1;
        return {5'(p), m, 3'(ln), (k == n - 1) ? 1'b1 : 1'b0};
    endfunction

    task automatic run(input int b, input int w, input bit m, input bit poke, input string tag);
        int n = lanes(b, w);
        bit ok = (n >= 1) && (n <= 4) && (b <= 32);
        int lat;
        @(negedge clk);
        bits_i = 6'(b); words_i = 3'(w); msb_i = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bits_i = 6'($urandom); words_i = 3'($urandom); msb_i = 1'($urandom);
        lat = 1;
        check({tag, " R8 busy after start"}, 64'(busy), 64'd1);
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1; bits_i = 6'd8; words_i = 3'd1; msb_i = ~m;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (ok) begin
            exp_lo = {12'b0, slot_model(b, w, m, 1), slot_model(b, w, m, 0)};
            exp_hi = {12'b0, slot_model(b, w, m, 3), slot_model(b, w, m, 2)};
            if (w != 0 || b == 32) exp_gran = 2'(b / 16);
        end
        check({tag, " R8 latency"}, 64'(lat), 64'(ok ? n + 2 : 2));
        check({tag, " R1 error flag"}, 64'(error), 64'(!ok));
        check({tag, " R2 R3 R4 R5 R6 cfg_lo"}, 64'(cfg_lo), 64'(exp_lo));
        check({tag, " R2 R3 R4 R5 R6 cfg_hi"}, 64'(cfg_hi), 64'(exp_hi));
        check({tag, " R7 gran"}, 64'(gran), 64'(exp_gran));
        @(negedge clk);
        check({tag, " R8 done pulse width"}, 64'(done), 64'd0);
        if (poke) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                check({tag, " R9 no second done"}, 64'(done), 64'd0);
            end
        end
    endtask

    initial begin
        #(20ns * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset busy", 64'(busy), 64'd0);
        check("R10 reset done", 64'(done), 64'd0);
        check("R10 reset error", 64'(error), 64'd0);
        check("R10 reset cfg", {cfg_hi, cfg_lo}, 64'd0);
        check("R10 reset gran", 64'(gran), 64'd0);
        rst = 1'b0;

        run(7, 4, 1'b1, 1'b0, "msb 7x4");
        run(15, 2, 1'b0, 1'b0, "lsb 15x2");
        run(23, 1, 1'b1, 1'b0, "msb 23x1");
        run(32, 1, 1'b0, 1'b0, "lsb 32x1 gran");
        run(16, 2, 1'b1, 1'b0, "msb 16x2");
        run(1, 4, 1'b0, 1'b0, "lsb 1x4");
        run(8, 1, 1'b1, 1'b0, "msb 8x1");
        run(9, 3, 1'b0, 1'b0, "R1 reject count 6");
        run(12, 0, 1'b1, 1'b0, "R1 reject no words");
        run(0, 2, 1'b1, 1'b0, "R1 reject zero width");
        run(40, 1, 1'b0, 1'b0, "R1 reject too wide");
        run(20, 1, 1'b1, 1'b1, "R9 start while busy");
        run(24, 1, 1'b0, 1'b0, "lsb 24x1");

        for (int t = 0; t < 200; t++) begin
            run($urandom_range(0, 40), $urandom_range(0, 7), 1'($urandom), 1'b0, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule